// File: doc/BRIEF.md
# Background In-Place RAM Pattern Tester

This block tests a synchronous single-port RAM one word at a time without destroying what the RAM holds. For every address it reads the word and keeps a copy. It then writes a checkerboard value and reads it back. It writes the complementary checkerboard value and reads that back too. If both read-backs match, it writes the kept copy back and moves on to the next address. A word that passes therefore holds its original data again before the tester leaves it.

The test is meant to run at low priority alongside normal traffic. A pause input stops the walk at the next word boundary and holds it there, so the RAM is never left holding a test pattern. While the walk is held, the surrounding logic can use the RAM. When the walk reaches the end, the block raises done. If a read-back does not match, the block stops at once and reports the failing address.

Top module: `ram_inplace_tester`

## Requirements
- R1: Reset leaves done, fail and mem_we low. A start pulse while the tester is idle or finished clears done and fail and begins the walk at address 0.
- R2: The RAM returns read data one cycle after the address is presented with mem_we low. Each word is written with pattern A, in which bit i equals i mod 2 (0xAA for 8 bits), and read back. It is then written with pattern B, which is the bitwise complement of A, and read back.
- R3: A word whose two read-backs both match gets its original contents written back. After a walk with no failure, every word holds exactly the value it held before start.
- R4: Words are visited in ascending address order, 0 to WORDS-1. Each word sees exactly three writes, in this order: A, then B, then the saved original.
- R5: Pause takes effect only after a word has been restored, never in the middle of a word. While the walk is held there are no writes and mem_addr stays fixed. When pause drops, the walk continues at the next address.
- R6: Done rises after the last word has been restored with no mismatch found, and fail stays low.
- R7: A read-back mismatch sets fail and done together and latches the failing address on fail_addr.
- R8: After a mismatch there are no further writes. The failing word keeps the pattern that was last written to it, and every later word is left untouched.
- R9: With pause low, done rises 6*WORDS clock edges after the edge that samples start, which is six cycles per word.
- R10: Start has no effect while a walk is in progress, including while it is held by pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a walk when the tester is idle or finished |
| pause | input | 1 | Holds the walk at the next word boundary |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable; a cycle with this low is a read |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the address |
| done | output | 1 | Walk finished, either passed or stopped on a failure |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The walk is run over RAM contents that are all zeros, all ones, equal to pattern A, and random. These show whether restoring really uses the saved word rather than one of the patterns or a constant. Stuck-bit faults are placed at random or edge addresses, with masks chosen so that either the A read-back or only the B read-back fails. These tell apart the two compare points, check where the walk stops, and check which pattern is left in the failing word. Pause is raised at arbitrary cycles within a word, and start is pulsed during a walk. These separate boundary-only pausing from mid-word stopping, and an ignored start from a restart.

// File: rtl/ram_inplace_tester.sv
module ram_inplace_tester #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int WORDS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pause,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  function automatic logic [DATA_W-1:0] checker_a();
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = i[0];
    return r;
  endfunction

  localparam logic [DATA_W-1:0] PAT_A = checker_a();
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(WORDS - 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_RD = 3'd1, S_W1 = 3'd2, S_R1 = 3'd3,
                         S_W2   = 3'd4, S_R2 = 3'd5, S_WB = 3'd6, S_HOLD = 3'd7;

  logic [2:0]        st;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] saved;

  wire match = mem_rdata == ((st == S_W2) ? PAT_A : PAT_B);

  assign mem_addr = addr;
  assign mem_we   = (st == S_W1) | (((st == S_W2) | (st == S_WB)) & match);

  always_comb begin
    case (st)
      S_W1:    mem_wdata = PAT_A;
      S_W2:    mem_wdata = PAT_B;
      default: mem_wdata = saved;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= '0;
      saved     <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr      <= '0;
          done      <= 1'b0;
          fail      <= 1'b0;
          fail_addr <= '0;
          st        <= S_RD;
        end
        S_RD: st <= S_W1;
        S_W1: begin
          saved <= mem_rdata;
          st    <= S_R1;
        end
        S_R1: st <= S_W2;
        S_W2: if (match) st <= S_R2;
              else begin
                fail      <= 1'b1;
                done      <= 1'b1;
                fail_addr <= addr;
                st        <= S_IDLE;
              end
        S_R2: st <= S_WB;
        S_WB: if (!match) begin
                fail      <= 1'b1;
                done      <= 1'b1;
                fail_addr <= addr;
                st        <= S_IDLE;
              end else if (addr == LAST) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                addr <= addr + 1'b1;
                st   <= pause ? S_HOLD : S_RD;
              end
        S_HOLD: if (!pause) st <= S_RD;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ram_inplace_tester_sva.sv
module ram_inplace_tester_sva #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        st,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr
);
  localparam logic [2:0] W2 = 3'd4, WB = 3'd6, HOLD = 3'd7;

  a_r3_restore_original: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WB && mem_we) |-> mem_wdata == $past(mem_rdata, 4));

  a_r2_second_is_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W2 && mem_we) |-> ($past(mem_we, 2) && mem_wdata == ~$past(mem_wdata, 2)
                              && mem_addr == $past(mem_addr, 2)));

  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |=> ($stable(mem_addr) && !mem_we));

  a_r6_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  a_r7_fail_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  a_r7_fail_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && $past(fail)) |-> $stable(fail_addr));
endmodule

bind ram_inplace_tester ram_inplace_tester_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .st(st), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done), .fail(fail), .fail_addr(fail_addr)
);

// File: tb/sim_ram_inplace_tester.sv
`timescale 1ns/1ps
module sim_ram_inplace_tester;
  localparam int AW = 5, DW = 8, N = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, pause;
  wire [AW-1:0] mem_addr, fail_addr;
  wire [DW-1:0] mem_wdata;
  wire mem_we, done, fail;
  logic [DW-1:0] mem_rdata = '0;

  ram_inplace_tester #(.ADDR_W(AW), .DATA_W(DW), .WORDS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pause(pause), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done),
    .fail(fail), .fail_addr(fail_addr));

  logic [DW-1:0] ram [N];
  logic [DW-1:0] snap [N];
  logic stuck_on = 1'b0;
  logic [AW-1:0] stuck_a = '0;
  logic [DW-1:0] stuck_m = '0, stuck_v = '0;

  always @(posedge clk) begin
    if (stuck_on && mem_addr == stuck_a)
      mem_rdata <= (ram[mem_addr] & ~stuck_m) | (stuck_v & stuck_m);
    else
      mem_rdata <= ram[mem_addr];
    if (mem_we) ram[mem_addr] <= mem_wdata;
  end

  function automatic logic [DW-1:0] pat_a();
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = i[0];
    return r;
  endfunction

  int wr_cnt = 0, seq_err = 0, mk;
  logic [DW-1:0] me;
  always @(posedge clk) if (mem_we) begin
    mk = wr_cnt % 3;
    me = (mk == 0) ? pat_a() : (mk == 1) ? ~pat_a() : snap[(wr_cnt / 3) % N];
    if (mem_addr != AW'(wr_cnt / 3) || mem_wdata != me) seq_err++;
    wr_cnt++;
  end

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int mode);
    for (int a = 0; a < N; a++) begin
      case (mode)
        0: ram[a] = '0;
        1: ram[a] = pat_a();
        2: ram[a] = '1;
        default: ram[a] = DW'($urandom);
      endcase
      snap[a] = ram[a];
    end
  endtask

  task automatic go(input int pulse_at, output int n);
    @(negedge clk);
    wr_cnt = 0; seq_err = 0; start = 1'b1;
    @(posedge clk); n = 1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 20000) begin
      start = (n == pulse_at);
      @(posedge clk); n++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int a = 0; a < N; a++) if (ram[a] != snap[a]) d++;
    return d;
  endfunction

  int n, wc, wev, mv, fa, bad;
  bit p1fail;
  logic [AW-1:0] ad;
  logic [DW-1:0] ev;

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; pause = 1'b0;
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !fail && !mem_we, "R1 reset outputs", {done, fail, mem_we}, 0);
    rst_n = 1'b1;

    for (int mode = 0; mode < 4; mode++) begin
      fill(mode);
      go(0, n);
      chk(n == 6 * N + 1, "R9 walk length", n, 6 * N + 1);
      chk(done && !fail, "R6 done without fail", {done, fail}, 2);
      chk(seq_err == 0 && wr_cnt == 3 * N, "R2 R4 write order", seq_err * 1000 + wr_cnt, 3 * N);
      chk(mem_diff() == 0, "R3 contents preserved", mem_diff(), 0);
    end

    for (int t = 0; t < 3; t++) begin
      fill(3);
      @(negedge clk);
      wr_cnt = 0; seq_err = 0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat ($urandom_range(5, 60)) @(negedge clk);
      pause = 1'b1;
      repeat (8) @(negedge clk);
      wc = wr_cnt; ad = mem_addr; wev = 0; mv = 0;
      for (int k = 0; k < 10; k++) begin
        start = (k == 3);
        @(negedge clk);
        if (mem_we) wev++;
        if (mem_addr != ad) mv++;
      end
      start = 1'b0;
      chk(wr_cnt == wc && wev == 0, "R5 R10 no writes while held", wev, 0);
      chk(wc % 3 == 0 && wc > 0, "R5 held on word boundary", wc % 3, 0);
      chk(mv == 0 && int'(ad) == wc / 3, "R5 address held at next word", ad, wc / 3);
      pause = 1'b0;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(done && !fail && seq_err == 0 && wr_cnt == 3 * N, "R5 resume completes", seq_err, 0);
      chk(mem_diff() == 0, "R3 R5 contents after pause", mem_diff(), 0);
    end

    fill(3);
    go(50, n);
    chk(n == 6 * N + 1 && seq_err == 0 && !fail, "R10 start ignored mid-walk", n, 6 * N + 1);
    chk(mem_diff() == 0, "R10 contents after stray start", mem_diff(), 0);

    for (int t = 0; t < 8; t++) begin
      fill(3);
      stuck_on = 1'b1;
      case (t)
        0: begin stuck_a = '0;        stuck_m = 8'h80; stuck_v = 8'h00; end
        1: begin stuck_a = AW'(N - 1); stuck_m = 8'h01; stuck_v = 8'h00; end
        2: begin stuck_a = AW'(7);     stuck_m = 8'h02; stuck_v = 8'h02; end
        default: begin
          stuck_a = AW'($urandom_range(0, N - 1));
          stuck_m = DW'($urandom_range(1, 255));
          stuck_v = DW'($urandom);
        end
      endcase
      fa = int'(stuck_a);
      p1fail = ((pat_a() ^ stuck_v) & stuck_m) != 0;
      go(0, n);
      chk(fail && done, "R7 fail and done", {fail, done}, 3);
      chk(fail_addr == stuck_a, "R7 fail address", fail_addr, fa);
      chk(seq_err == 0 && wr_cnt == 3 * fa + (p1fail ? 1 : 2), "R8 writes stop at fault",
          wr_cnt, 3 * fa + (p1fail ? 1 : 2));
      bad = 0;
      for (int a = 0; a < N; a++) begin
        ev = (a == fa) ? (p1fail ? pat_a() : ~pat_a()) : snap[a];
        if (ram[a] != ev) bad++;
      end
      chk(bad == 0, "R8 failing word not restored, others intact", bad, 0);
      stuck_on = 1'b0;
    end

    fill(3);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!fail && !done, "R1 start clears fail and done", {fail, done}, 0);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done && !fail && mem_diff() == 0, "R6 clean rerun", {done, fail}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule